// File: doc/BRIEF.md
# Start-up and Lock-Loss Output Mute Sequencer

This block decides when the sample stream headed for the serial audio port carries real converter data. It watches a supply-good level, which may arrive from another clock domain. It holds the converter core in reset for a fixed number of system clocks after that level has settled high. It then keeps the outgoing samples at zero while the decimation filter fills with valid history. That wait is counted in word-clock sample periods, so it takes the same time at every system-clock-to-sample-rate ratio.

Once running, the block also follows a lock indication from the clock-relationship monitor. If lock drops, output is muted straight away and held at bipolar zero, which is all-zero in two's complement. When lock comes back, a shorter zero-fill interval, again counted in sample periods, runs before live samples flow again. Losing lock during either fill interval abandons it. After the next recovery, a full zero-fill interval runs from the start. A drop of the supply-good level from any state returns the whole sequence to reset.

Top module: `pcm_out_gate`

## Requirements
- R1: While the synchronised supply-good level is low, `core_rst` is 1 and `smp_out` is 0. `pwr_good` passes through SYNC_STAGES (default 2) flops, so a falling `pwr_good` forces `core_rst` high by the third clock edge that samples it low.
- R2: Number the first clock edge that samples `pwr_good` high as edge 1. `core_rst` first reads 0 after edge RST_CYCLES+2, with the default two-stage synchroniser.
- R3: Counted from the edge that releases `core_rst`, `smp_out` stays 0 until the edge that samples the SETTLE_SAMPLES-th `smp_stb` pulse. From that edge on, `smp_out` carries `smp_in`. A strobe on the release edge itself is not counted.
- R4: In the live state, `smp_out` equals the `smp_in` value sampled at the previous clock edge.
- R5: A low `lock_ok` sampled at an edge, in any state other than reset, makes `smp_out` 0 after that same edge.
- R6: While lock is absent, `smp_out` is held at bipolar zero, the all-zero two's-complement code, whatever `smp_in` carries.
- R7: The first edge that samples `lock_ok` high while unlocked starts a zero-fill interval, and a strobe on that edge is not counted. Live data resumes at the edge that samples the REZERO_SAMPLES-th later strobe.
- R8: A loss of lock during the start-up settle interval or the zero-fill interval returns the block to the unlocked state. After the next recovery, the full REZERO_SAMPLES count is required.
- R9: A fall of `pwr_good` from any state restarts the whole sequence, with the full reset count and the full settle count.
- R10: `lock_ok` is ignored while `core_rst` is high, so the release edge of R2 does not depend on it. Sample counts depend only on `smp_stb` pulses, not on how far apart they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-good level, may be asynchronous |
| smp_stb | input | 1 | One-cycle pulse per sample period, synchronous to clk |
| lock_ok | input | 1 | Clock-lock status, synchronous to clk, 1 = locked |
| smp_in | input | DATA_W | Filtered sample from the decimator |
| core_rst | output | 1 | Active-high reset for the converter core |
| smp_out | output | DATA_W | Gated sample to the serial port |

## Verification
The assertions assume that `lock_ok`, `smp_stb` and `smp_in` are already synchronous to `clk`, and that `smp_stb` is a single-cycle pulse. Only `pwr_good` is taken as possibly asynchronous, and it is resynchronised internally. The stimulus changes every input on the falling clock edge, so each level is stable at the rising edge that samples it. Strobes come on an irregular pattern so that the counts do not depend on a fixed spacing. Lock is dropped during reset, during the settle interval, in live operation and partway through a zero-fill interval.

// File: rtl/pcm_out_gate_pkg.sv
package pcm_out_gate_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_LIVE   = 3'd2,
    ST_NOLOCK = 3'd3,
    ST_REFILL = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q = '0;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain_q <= async_in;
    end else begin : g_many
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic         hit
);
  logic [W-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    if (clr)      cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = inc & (cnt_q == last);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pcm_out_gate_pkg::*;
(
  input  logic       clk,
  input  logic       pg_s,
  input  logic       lock_ok,
  input  logic       smp_stb,
  input  logic       rst_hit,
  input  logic       smp_hit,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       rst_clr,
  output logic       rst_inc,
  output logic       smp_clr,
  output logic       smp_inc,
  output logic       smp_sel_settle
);
  seq_state_t cur_q = ST_HOLD;

  always_comb begin
    state_d = cur_q;
    if (!pg_s) begin
      state_d = ST_HOLD;
    end else begin
      unique case (cur_q)
        ST_HOLD:   if (rst_hit) state_d = ST_SETTLE;
        ST_SETTLE: if (!lock_ok) state_d = ST_NOLOCK;
                   else if (smp_hit) state_d = ST_LIVE;
        ST_LIVE:   if (!lock_ok) state_d = ST_NOLOCK;
        ST_NOLOCK: if (lock_ok) state_d = ST_REFILL;
        ST_REFILL: if (!lock_ok) state_d = ST_NOLOCK;
                   else if (smp_hit) state_d = ST_LIVE;
        default:   state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) cur_q <= state_d;

  assign state_q        = cur_q;
  assign rst_inc        = pg_s & (cur_q == ST_HOLD);
  assign rst_clr        = ~pg_s | (cur_q != ST_HOLD) | rst_hit;
  assign smp_sel_settle = (cur_q == ST_SETTLE);
  assign smp_inc        = smp_stb & lock_ok & pg_s &
                          ((cur_q == ST_SETTLE) | (cur_q == ST_REFILL));
  assign smp_clr        = (state_d != cur_q);
endmodule

// File: rtl/pcm_out_gate.sv
module pcm_out_gate
  import pcm_out_gate_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int RST_CYCLES     = 1024,
  parameter int SETTLE_SAMPLES = 18436,
  parameter int REZERO_SAMPLES = 32
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              smp_stb,
  input  logic              lock_ok,
  input  logic [DATA_W-1:0] smp_in,
  output logic              core_rst,
  output logic [DATA_W-1:0] smp_out
);
  localparam int RST_W   = $clog2(RST_CYCLES + 1);
  localparam int SMP_MAX = (SETTLE_SAMPLES > REZERO_SAMPLES) ? SETTLE_SAMPLES : REZERO_SAMPLES;
  localparam int SMP_W   = $clog2(SMP_MAX + 1);
  localparam logic [RST_W-1:0] RST_LAST    = RST_W'(RST_CYCLES - 1);
  localparam logic [SMP_W-1:0] SETTLE_LAST = SMP_W'(SETTLE_SAMPLES - 1);
  localparam logic [SMP_W-1:0] REFILL_LAST = SMP_W'(REZERO_SAMPLES - 1);

  logic       pg_s;
  logic       rst_hit, smp_hit;
  logic       rst_clr, rst_inc, smp_clr, smp_inc, smp_sel_settle;
  seq_state_t state_q, state_d;

  logic              rst_q = 1'b1;
  logic [DATA_W-1:0] out_q = '0;

  pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .async_in(pwr_good), .sync_out(pg_s)
  );

  seq_counter #(.W(RST_W)) u_rst_cnt (
    .clk(clk), .clr(rst_clr), .inc(rst_inc), .last(RST_LAST), .hit(rst_hit)
  );

  seq_counter #(.W(SMP_W)) u_smp_cnt (
    .clk(clk), .clr(smp_clr), .inc(smp_inc),
    .last(smp_sel_settle ? SETTLE_LAST : REFILL_LAST), .hit(smp_hit)
  );

  seq_fsm u_fsm (
    .clk(clk), .pg_s(pg_s), .lock_ok(lock_ok), .smp_stb(smp_stb),
    .rst_hit(rst_hit), .smp_hit(smp_hit),
    .state_q(state_q), .state_d(state_d),
    .rst_clr(rst_clr), .rst_inc(rst_inc),
    .smp_clr(smp_clr), .smp_inc(smp_inc), .smp_sel_settle(smp_sel_settle)
  );

  always_ff @(posedge clk) begin
    rst_q <= (state_d == ST_HOLD);
    out_q <= (state_d == ST_LIVE) ? smp_in : '0;
  end

  assign core_rst = rst_q;
  assign smp_out  = out_q;

  logic chk_en = 1'b0;
  always_ff @(posedge clk) chk_en <= 1'b1;

  AST_RST_ON_PG_LOW: assert property (@(posedge clk) disable iff (!chk_en)
    (!pg_s) |=> core_rst); // R1
  AST_RELEASE_ON_COUNT: assert property (@(posedge clk) disable iff (!chk_en)
    $fell(core_rst) |-> $past(rst_hit)); // R2
  AST_MUTE_IN_RST: assert property (@(posedge clk) disable iff (!chk_en)
    core_rst |-> (smp_out == '0)); // R3
  AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!chk_en)
    (state_q == ST_LIVE && lock_ok && pg_s) |=> (smp_out == $past(smp_in))); // R4
  AST_MUTE_ON_LOCK_LOSS: assert property (@(posedge clk) disable iff (!chk_en)
    (!lock_ok && state_q != ST_HOLD) |=> (smp_out == '0)); // R5
  AST_REFILL_ON_RELOCK: assert property (@(posedge clk) disable iff (!chk_en)
    (state_q == ST_NOLOCK && lock_ok && pg_s) |=> (state_q == ST_REFILL)); // R7
endmodule

// File: tb/sim_pcm_out_gate.sv
module sim_pcm_out_gate;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int RSTC = 20;
  localparam int SETL = 50;
  localparam int REZ  = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          pwr_good = 1'b0;
  logic          smp_stb  = 1'b0;
  logic          lock_ok  = 1'b0;
  logic [DW-1:0] din      = '0;
  logic          core_rst;
  logic [DW-1:0] smp_out;

  pcm_out_gate #(.DATA_W(DW), .SYNC_STAGES(2), .RST_CYCLES(RSTC),
                 .SETTLE_SAMPLES(SETL), .REZERO_SAMPLES(REZ)) u0 (
    .clk(clk), .pwr_good(pwr_good), .smp_stb(smp_stb), .lock_ok(lock_ok),
    .smp_in(din), .core_rst(core_rst), .smp_out(smp_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] prev_din = '0;
  logic          prev_stb = 1'b0;

  // behavioural reference: modes 0 hold, 1 settle, 2 live, 3 unlocked, 4 refill
  int m_meta = 0, m_pg = 0, m_mode = 0, m_cnt = 0;
  logic          exp_rst = 1'b1;
  logic [DW-1:0] exp_out = '0;

  always @(posedge clk) begin
    automatic int nm = m_mode;
    if (m_pg == 0) begin
      nm = 0; m_cnt = 0;
    end else begin
      case (m_mode)
        0: begin m_cnt++; if (m_cnt == RSTC) begin nm = 1; m_cnt = 0; end end
        1, 4: begin
          if (!lock_ok) begin nm = 3; m_cnt = 0; end
          else if (smp_stb) begin
            m_cnt++;
            if (m_cnt == ((m_mode == 1) ? SETL : REZ)) begin nm = 2; m_cnt = 0; end
          end
        end
        2: if (!lock_ok) begin nm = 3; m_cnt = 0; end
        3: if (lock_ok) begin nm = 4; m_cnt = 0; end
        default: nm = 0;
      endcase
    end
    m_mode  = nm;
    exp_rst = (nm == 0);
    exp_out = (nm == 2) ? din : '0;
    m_pg    = m_meta;
    m_meta  = pwr_good ? 1 : 0;
  end

  function automatic string mtag();
    case (m_mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({mtag(), " rst"}, 32'(core_rst), 32'(exp_rst));
    chk({mtag(), " out"}, 32'(smp_out), 32'(exp_out));
    prev_din = din;
    prev_stb = smp_stb;
    din      = DW'($urandom) | DW'(1);
    smp_stb  = (($urandom % 3) == 0);
  endtask

  // counts sampled strobes; output stays zero until the target-th one
  task automatic run_count(int target, string tag);
    int s = 0;
    for (int i = 0; i < 20000; i++) begin
      tick();
      if (prev_stb) s++;
      if (s < target) chk(tag, 32'(smp_out), 32'd0);
      else begin chk(tag, 32'(smp_out), 32'(prev_din)); break; end
    end
  endtask

  task automatic release_count(string tag, bit raise_lock);
    int n = 0;
    for (int i = 0; i < 2000; i++) begin
      tick();
      n++;
      if (raise_lock && n == 5) lock_ok = 1'b1;
      if (!core_rst) break;
    end
    chk(tag, 32'(n), 32'(RSTC + 2));
  endtask

  initial begin
    // R1: supply low, clocks running
    repeat (4) tick();
    chk("R1", 32'(core_rst), 32'd1);
    chk("R1", 32'(smp_out), 32'd0);

    // R2 / R10: release timing with lock low during the first part of reset
    pwr_good = 1'b1;
    release_count("R2 R10", 1'b1);

    run_count(SETL, "R3");
    for (int i = 0; i < 30; i++) begin
      tick();
      chk("R4", 32'(smp_out), 32'(prev_din));
    end

    lock_ok = 1'b0;
    tick();
    chk("R5", 32'(smp_out), 32'd0);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R6", 32'(smp_out), 32'd0);
    end
    lock_ok = 1'b1;
    tick();
    chk("R7", 32'(smp_out), 32'd0);
    run_count(REZ, "R7");
    repeat (10) tick();

    // R8: lose lock halfway through a zero-fill
    lock_ok = 1'b0;
    repeat (5) tick();
    lock_ok = 1'b1;
    tick();
    begin
      int s = 0;
      while (s < REZ / 2) begin
        tick();
        if (prev_stb) s++;
        chk("R8", 32'(smp_out), 32'd0);
      end
    end
    lock_ok = 1'b0;
    tick();
    chk("R8", 32'(smp_out), 32'd0);
    repeat (3) tick();
    lock_ok = 1'b1;
    tick();
    run_count(REZ, "R8");

    // R8: lose lock during start-up settle, later needs only REZ
    // R9: supply drop from live
    pwr_good = 1'b0;
    repeat (3) tick();
    chk("R9", 32'(core_rst), 32'd1);
    chk("R9", 32'(smp_out), 32'd0);
    repeat (3) tick();
    pwr_good = 1'b1;
    release_count("R9", 1'b0);
    begin
      int s = 0;
      while (s < SETL / 3) begin
        tick();
        if (prev_stb) s++;
        chk("R9", 32'(smp_out), 32'd0);
      end
    end
    lock_ok = 1'b0;
    tick();
    chk("R8", 32'(smp_out), 32'd0);
    repeat (4) tick();
    lock_ok = 1'b1;
    tick();
    run_count(REZ, "R8");
    repeat (20) tick();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule